// File: doc/BRIEF.md
# Dual Word Buffer with DMA Write Request

This block sits between the system bus side and the serial flash side of a flash controller and buffers 32-bit words in both directions. The transmit buffer collects words from the bus or a DMA engine until the flash side takes them. The receive buffer collects words read from the flash until the bus side takes them. Both buffers share one clock. Each buffer reports its fill count, full and empty, plus almost-full and almost-empty against thresholds that software can program.

A DMA write request tells the DMA engine to refill the transmit buffer. A mode input picks the moment the request rises. In one mode it rises as soon as the buffer drains to its almost-empty level. In the other mode it waits until the buffer is fully empty.

Two sticky status bits record overflow and underflow events. A status bit is cleared by writing 1 to its bit. A status bit only reaches the interrupt line when its enable is set.

Top module: `flash_word_buffer`

## Requirements
- R1: Each buffer holds DEPTH (64) words of DW (32) bits in first-in first-out order. A pop accepted at a clock edge presents the oldest word on the matching pop_data output from that edge on. pop_data is 0 after reset.
- R2: The count outputs update at the same edge that accepts a push or pop. A push and a pop in the same cycle on a buffer that is not empty leave the count unchanged. The count never exceeds DEPTH.
- R3: A buffer's almost-full flag is 1 exactly when its count is greater than or equal to its almost-full threshold. The flag uses the threshold value from the cycle before the edge and is valid at the same edge as the count.
- R4: A buffer's almost-empty flag is 1 exactly when its count is less than or equal to its almost-empty threshold. The timing is the same as for R3.
- R5: When dma_on_empty is 0, dma_wreq equals the transmit buffer's almost-empty flag, delayed by one clock.
- R6: When dma_on_empty is 1, dma_wreq equals the transmit buffer's empty flag, delayed by one clock.
- R7: A push to a full buffer with no pop in the same cycle is dropped. The count and the stored words do not change, and status bit 0 (overflow) is set.
- R8: A pop from an empty buffer leaves pop_data at its last value and the count at 0, and sets status bit 1 (underflow).
- R9: A 1 on an irq_clr bit clears that status bit at the next edge. If the same bit's event occurs in that same cycle, the bit stays set. Without a clear, a status bit stays set.
- R10: irq is registered and equals the OR of the status bits ANDed with irq_en, where irq_en is taken from the cycle before the edge.
- R11: Reset (rst high at a clock edge) empties both buffers. After reset both counts are 0, empty is 1, full is 0, the status bits are 0, and irq and dma_wreq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_push | input | 1 | Push a word into the transmit buffer |
| wr_push_data | input | DW | Word to push into the transmit buffer |
| wr_pop | input | 1 | Pop a word from the transmit buffer (flash side) |
| wr_pop_data | output | DW | Word popped from the transmit buffer |
| wr_count | output | CW | Transmit buffer fill count |
| wr_full | output | 1 | Transmit buffer full |
| wr_empty | output | 1 | Transmit buffer empty |
| wr_afull | output | 1 | Transmit buffer almost full |
| wr_aempty | output | 1 | Transmit buffer almost empty |
| rd_push | input | 1 | Push a word into the receive buffer (flash side) |
| rd_push_data | input | DW | Word to push into the receive buffer |
| rd_pop | input | 1 | Pop a word from the receive buffer |
| rd_pop_data | output | DW | Word popped from the receive buffer |
| rd_count | output | CW | Receive buffer fill count |
| rd_full | output | 1 | Receive buffer full |
| rd_empty | output | 1 | Receive buffer empty |
| rd_afull | output | 1 | Receive buffer almost full |
| rd_aempty | output | 1 | Receive buffer almost empty |
| wr_afull_lvl | input | CW | Transmit almost-full threshold |
| wr_aempty_lvl | input | CW | Transmit almost-empty threshold |
| rd_afull_lvl | input | AW | Receive almost-full threshold |
| rd_aempty_lvl | input | AW | Receive almost-empty threshold |
| dma_on_empty | input | 1 | 0: request at almost empty, 1: request at empty |
| dma_wreq | output | 1 | DMA write (refill) request |
| irq_en | input | 2 | Per-bit status enable |
| irq_clr | input | 2 | Write-1-to-clear pulses for the status bits |
| irq_stat | output | 2 | Sticky status: bit 0 overflow, bit 1 underflow |
| irq | output | 1 | Interrupt line |

## Verification
Counts, full, empty and both threshold flags are due at the first clock edge after the push or pop that changes them. Popped data is due at the same edge. The status bits and irq follow their event or clear by one edge. dma_wreq follows the transmit flags by one more edge, so it is two edges after the push or pop. The bench drives every input on the falling edge and samples on the falling edge after the edge where a result is due. For each check it advances exactly that many rising edges, one for counts, flags, data and status, two for the DMA request, so no sample races an update.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  // status bit positions, decoded by the bench and by software
  localparam int unsigned STAT_OVF = 0;
  localparam int unsigned STAT_UNF = 1;
  localparam int unsigned STAT_N   = 2;
endpackage

// File: rtl/fwb_fifo.sv
module fwb_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int AFW   = 7,
  parameter int AEW   = 7,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [DW-1:0]  din,
  input  logic           pop,
  output logic [DW-1:0]  dout,
  input  logic [AFW-1:0] afull_lvl,
  input  logic [AEW-1:0] aempty_lvl,
  output logic [CW-1:0]  count,
  output logic           full,
  output logic           empty,
  output logic           afull,
  output logic           aempty,
  output logic           drop,
  output logic           starve
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_next;
  logic          push_ok, pop_ok;

  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop);
  assign drop    = push && full && !pop;
  assign starve  = pop && empty;

  always_comb begin
    if (rst) cnt_next = '0;
    else     cnt_next = count + CW'(push_ok) - CW'(pop_ok);
  end

  // storage: single write port, registered read port
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (pop_ok) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
    end
  end

  // flags registered from the next count so they line up with count
  always_ff @(posedge clk) begin
    count  <= cnt_next;
    full   <= (cnt_next == CW'(DEPTH));
    empty  <= (cnt_next == '0);
    afull  <= (cnt_next >= CW'(afull_lvl));
    aempty <= (cnt_next <= CW'(aempty_lvl));
  end
endmodule

// File: rtl/fwb_irq.sv
module fwb_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] stat,
  output logic         irq
);
  logic [N-1:0] stat_next;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (rst) stat_next[i] = 1'b0;
      else     stat_next[i] = set[i] | (stat[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk) begin
    stat <= stat_next;
    irq  <= |(stat_next & en);
  end
endmodule

// File: rtl/flash_word_buffer.sv
module flash_word_buffer #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NS   = fwb_pkg::STAT_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_push,
  input  logic [DW-1:0] wr_push_data,
  input  logic          wr_pop,
  output logic [DW-1:0] wr_pop_data,
  output logic [CW-1:0] wr_count,
  output logic          wr_full,
  output logic          wr_empty,
  output logic          wr_afull,
  output logic          wr_aempty,
  input  logic          rd_push,
  input  logic [DW-1:0] rd_push_data,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_pop_data,
  output logic [CW-1:0] rd_count,
  output logic          rd_full,
  output logic          rd_empty,
  output logic          rd_afull,
  output logic          rd_aempty,
  input  logic [CW-1:0] wr_afull_lvl,
  input  logic [CW-1:0] wr_aempty_lvl,
  input  logic [AW-1:0] rd_afull_lvl,
  input  logic [AW-1:0] rd_aempty_lvl,
  input  logic          dma_on_empty,
  output logic          dma_wreq,
  input  logic [NS-1:0] irq_en,
  input  logic [NS-1:0] irq_clr,
  output logic [NS-1:0] irq_stat,
  output logic          irq
);
  logic wr_drop, wr_starve, rd_drop, rd_starve;
  logic [NS-1:0] events;

  fwb_fifo #(.DW(DW), .DEPTH(DEPTH), .AFW(CW), .AEW(CW)) u_txq (
    .clk(clk), .rst(rst),
    .push(wr_push), .din(wr_push_data),
    .pop(wr_pop), .dout(wr_pop_data),
    .afull_lvl(wr_afull_lvl), .aempty_lvl(wr_aempty_lvl),
    .count(wr_count), .full(wr_full), .empty(wr_empty),
    .afull(wr_afull), .aempty(wr_aempty),
    .drop(wr_drop), .starve(wr_starve)
  );

  fwb_fifo #(.DW(DW), .DEPTH(DEPTH), .AFW(AW), .AEW(AW)) u_rxq (
    .clk(clk), .rst(rst),
    .push(rd_push), .din(rd_push_data),
    .pop(rd_pop), .dout(rd_pop_data),
    .afull_lvl(rd_afull_lvl), .aempty_lvl(rd_aempty_lvl),
    .count(rd_count), .full(rd_full), .empty(rd_empty),
    .afull(rd_afull), .aempty(rd_aempty),
    .drop(rd_drop), .starve(rd_starve)
  );

  always_comb begin
    events = '0;
    events[fwb_pkg::STAT_OVF] = wr_drop | rd_drop;
    events[fwb_pkg::STAT_UNF] = wr_starve | rd_starve;
  end

  fwb_irq #(.N(NS)) u_irq (
    .clk(clk), .rst(rst),
    .set(events), .clr(irq_clr), .en(irq_en),
    .stat(irq_stat), .irq(irq)
  );

  // refill request follows the registered transmit flags
  always_ff @(posedge clk) begin
    if (rst) dma_wreq <= 1'b0;
    else     dma_wreq <= dma_on_empty ? wr_empty : wr_aempty;
  end
endmodule

// File: rtl/fwb_checker.sv
module fwb_checker #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_push,
  input logic          wr_pop,
  input logic          wr_full,
  input logic          wr_empty,
  input logic          wr_aempty,
  input logic [CW-1:0] wr_count,
  input logic          rd_push,
  input logic          rd_pop,
  input logic          rd_empty,
  input logic [CW-1:0] rd_count,
  input logic [DW-1:0] rd_pop_data,
  input logic          dma_on_empty,
  input logic          dma_wreq,
  input logic [1:0]    irq_en,
  input logic [1:0]    irq_clr,
  input logic [1:0]    irq_stat,
  input logic          irq
);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_count <= CW'(DEPTH)) && (rd_count <= CW'(DEPTH)));

  p_drop_keeps_count_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_push && wr_full && !wr_pop) |=> ($stable(wr_count) && irq_stat[0]));

  p_starve_holds_data_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && rd_empty && !rd_push) |=>
      ($stable(rd_pop_data) && rd_count == '0 && irq_stat[1]));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_stat[0] && !irq_clr[0]) |=> irq_stat[0]);

  p_irq_or_r10: assert property (@(posedge clk) disable iff (rst)
    irq == |(irq_stat & $past(irq_en)));

  p_dma_empty_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(dma_on_empty) && dma_wreq) |-> $past(wr_empty));

  p_dma_aempty_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!dma_on_empty) && $past(wr_aempty) && !$past(rst)) |-> dma_wreq);
endmodule

bind flash_word_buffer fwb_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_flash_word_buffer.sv
module sim_flash_word_buffer;
  localparam int DW = 32;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_push = 0, wr_pop = 0, rd_push = 0, rd_pop = 0;
  logic [DW-1:0] wr_push_data = '0, rd_push_data = '0;
  logic [DW-1:0] wr_pop_data, rd_pop_data;
  logic [CW-1:0] wr_count, rd_count;
  logic wr_full, wr_empty, wr_afull, wr_aempty;
  logic rd_full, rd_empty, rd_afull, rd_aempty;
  logic [CW-1:0] wr_afull_lvl = CW'(60), wr_aempty_lvl = '0;
  logic [AW-1:0] rd_afull_lvl = AW'(60), rd_aempty_lvl = '0;
  logic dma_on_empty = 0, dma_wreq;
  logic [1:0] irq_en = '0, irq_clr = '0, irq_stat;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  flash_word_buffer #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    chk("R11 wr_count", 32'(wr_count), 0);
    chk("R11 rd_empty", 32'(rd_empty), 1);
    chk("R11 wr_full", 32'(wr_full), 0);
    chk("R11 irq_stat", 32'(irq_stat), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 dma_wreq", 32'(dma_wreq), 0);
    chk("R11 pop_data", rd_pop_data, 0);
    rst = 1'b0;
    step();
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) begin
      wr_push = 1; wr_push_data = 32'h1000 + i; step();
    end
    wr_push = 0;
    chk("R2 count after 3 pushes", 32'(wr_count), 3);
    for (int i = 0; i < 3; i++) begin
      wr_pop = 1; step();
      chk("R1 fifo order", wr_pop_data, 32'h1000 + i);
    end
    wr_pop = 0;
    chk("R2 count drained", 32'(wr_count), 0);
  endtask

  task automatic t_simul();
    wr_push = 1; wr_push_data = 32'hA; step();
    wr_push_data = 32'hB; step();
    wr_push_data = 32'hC; wr_pop = 1; step();
    wr_push = 0;
    chk("R2 push+pop keeps count", 32'(wr_count), 2);
    chk("R1 push+pop data", wr_pop_data, 32'hA);
    step(); chk("R1 second", wr_pop_data, 32'hB);
    step(); chk("R1 third", wr_pop_data, 32'hC);
    wr_pop = 0;
    chk("R2 empty again", 32'(wr_empty), 1);
  endtask

  task automatic t_flags();
    rd_afull_lvl = AW'(3); rd_aempty_lvl = AW'(1);
    rd_push = 1; rd_push_data = 32'h77; step();
    rd_push = 0;
    chk("R4 aempty at 1<=1", 32'(rd_aempty), 1);
    chk("R3 afull at 1<3", 32'(rd_afull), 0);
    rd_push = 1; step(); step();
    rd_push = 0;
    chk("R4 aempty at 3>1", 32'(rd_aempty), 0);
    chk("R3 afull at 3>=3", 32'(rd_afull), 1);
    rd_pop = 1; step(); step(); step();
    rd_pop = 0;
    chk("R2 rd drained", 32'(rd_count), 0);
    rd_afull_lvl = AW'(60);
  endtask

  task automatic t_dma();
    wr_aempty_lvl = CW'(2); dma_on_empty = 0;
    step(); step();
    chk("R5 req on empty fifo", 32'(dma_wreq), 1);
    wr_push = 1; step(); step(); step();
    wr_push = 0; step();
    chk("R5 req low at count 3", 32'(dma_wreq), 0);
    wr_pop = 1; step();
    wr_pop = 0; step();
    chk("R5 req back at count 2", 32'(dma_wreq), 1);
    dma_on_empty = 1; step();
    chk("R6 req low while not empty", 32'(dma_wreq), 0);
    wr_pop = 1; step();
    wr_pop = 0; step();
    chk("R6 req low at count 1", 32'(dma_wreq), 0);
    wr_pop = 1; step();
    wr_pop = 0; step();
    chk("R6 req at empty", 32'(dma_wreq), 1);
    dma_on_empty = 0; wr_aempty_lvl = '0;
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) begin
      wr_push = 1; wr_push_data = 32'hA000 + i; step();
    end
    chk("R2 full", 32'(wr_full), 1);
    chk("R7 no flag before drop", 32'(irq_stat[0]), 0);
    wr_push_data = 32'hDEAD; step();
    wr_push = 0;
    chk("R7 count held", 32'(wr_count), DEPTH);
    chk("R7 overflow set", 32'(irq_stat[0]), 1);
    wr_pop = 1;
    for (int i = 0; i < DEPTH; i++) begin
      step();
      chk("R7 contents unchanged", wr_pop_data, 32'hA000 + i);
    end
    wr_pop = 0;
    chk("R7 empty after drain", 32'(wr_empty), 1);
    irq_clr = 2'b01; step(); irq_clr = '0;
  endtask

  task automatic t_underflow();
    rd_push = 1; rd_push_data = 32'h55; step();
    rd_push = 0; rd_pop = 1; step();
    chk("R1 rd pop", rd_pop_data, 32'h55);
    chk("R8 no flag yet", 32'(irq_stat[1]), 0);
    step();
    rd_pop = 0;
    chk("R8 data held", rd_pop_data, 32'h55);
    chk("R8 count zero", 32'(rd_count), 0);
    chk("R8 underflow set", 32'(irq_stat[1]), 1);
  endtask

  task automatic t_w1c();
    step();
    chk("R9 sticky", 32'(irq_stat[1]), 1);
    irq_clr = 2'b10; step(); irq_clr = '0;
    chk("R9 cleared", 32'(irq_stat[1]), 0);
    irq_clr = 2'b10; rd_pop = 1; step();
    irq_clr = '0; rd_pop = 0;
    chk("R9 set wins over clear", 32'(irq_stat[1]), 1);
    chk("R9 other bit untouched", 32'(irq_stat[0]), 0);
  endtask

  task automatic t_irq();
    irq_en = 2'b00; step();
    chk("R10 masked", 32'(irq), 0);
    irq_en = 2'b10; step();
    chk("R10 enabled", 32'(irq), 1);
    irq_en = 2'b01; step();
    chk("R10 wrong enable", 32'(irq), 0);
    irq_en = 2'b11; irq_clr = 2'b10; step();
    irq_clr = '0;
    chk("R10 cleared drops irq", 32'(irq), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_simul();
    t_flags();
    t_dma();
    t_overflow();
    t_underflow();
    t_w1c();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule